// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Power-Up Hold-Off

This block gathers interrupt sources into two 32-bit sub-groups and one 32-bit top-level pending register, then reduces everything to a single interrupt line. One sub-group serves an endpoint core and the other a DMA engine. Each sub-group keeps a pending register that software sets and clears through separate write-one ports, and a mask register. The unmasked pending bits of each sub-group are reduced to summary bits in the top-level register. The endpoint group is split into a transmit half and a receive half, and each half has its own summary bit. The top-level register also takes software set and clear writes, and it latches two hardware event pulses: an on-the-go timer expiry and a bus-voltage change.

A configuration bit selects the sense of the output. It either reports "something unmasked is pending" or "nothing unmasked is pending". When the supply comes up, the output is held low for a programmable number of clock cycles. The hold-off is released only if power is still present when the count runs out. Software reaches every register through a single-cycle 32-bit write port and a combinational read port.

Top module: `irq_aggregator`

## Requirements
- R1: The register address is `reg_addr_i[3:2]` = group (0 endpoint, 1 DMA, 2 top-level, 3 configuration) and `reg_addr_i[1:0]` = function (0 status, 1 set, 2 clear, 3 mask). A write to a set address ORs the data into that group's pending bits. A write to a clear address removes the bits written as one.
- R2: In the top-level register, bit 9 is high exactly when an endpoint pending bit in 15:0 is high and its mask bit is 0. Bit 8 does the same for endpoint bits 31:16. Both bits track the group state level-wise, and a mask bit of 1 disables its source.
- R3: Top-level bit 24 is high exactly when some DMA pending bit is high with its mask bit 0. It falls when no such bit remains.
- R4: A one-cycle pulse on `otg_tmo_evt_i` sets top-level bit 16, and a pulse on `vbus_chg_evt_i` sets bit 15. If a clear write to the same bit falls in the same cycle, the set wins.
- R5: Configuration bit 17 (address 12) selects polarity. When it is 1, `irq_o` is high when any top-level bit is pending with its mask bit 0. When it is 0, `irq_o` is high only when no such bit exists. Either way, `irq_o` is also gated by the hold-off of R7.
- R6: After reset, the top-level mask reads 0xFFFFFFFF. All pending registers, both sub-group masks and the configuration register read 0, and `irq_o` is 0.
- R7: A clock edge that sees `pwr_on_i` high after it was low forces `irq_o` low from that edge on. Exactly SETTLE_CYCLES edges later, the output is enabled if `pwr_on_i` is still high. Dropping power leaves the enable as it is, and no enable happens while power is off.
- R8: Reads at the status, set and clear addresses of a group all return that group's pending value. A read at its mask address returns the mask. Address 12 returns the configuration register, and addresses 13 to 15 return 0.
- R9: Software set and clear writes to top-level bits 8, 9 and 24 have no effect. Those bits show only the summaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_i | input | 1 | Supply present level |
| otg_tmo_evt_i | input | 1 | Timer expiry event pulse (top bit 16) |
| vbus_chg_evt_i | input | 1 | Bus voltage change event pulse (top bit 15) |
| reg_wr_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 4 | Register word address {group, function} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Aggregated interrupt output |

## Verification
The assertions assume that the register port carries at most one write per cycle. Under that assumption, a clear-all write to a sub-group must empty its summaries on the next edge, because no other path can set sub-group bits. They also assume that `pwr_on_i` changes only at clock-edge granularity. The bench keeps to both rules: it drives every input at the falling edge, holds each write strobe for exactly one cycle, and lets an event pulse overlap only a top-level clear.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    GRP_EP  = 2'd0,
    GRP_DMA = 2'd1,
    GRP_TOP = 2'd2,
    GRP_CFG = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    FN_STATUS = 2'd0,
    FN_SET    = 2'd1,
    FN_CLEAR  = 2'd2,
    FN_MASK   = 2'd3
  } fn_e;

  localparam int unsigned TOP_RX_BIT   = 8;
  localparam int unsigned TOP_TX_BIT   = 9;
  localparam int unsigned TOP_VBUS_BIT = 15;
  localparam int unsigned TOP_OTG_BIT  = 16;
  localparam int unsigned TOP_DMA_BIT  = 24;
  localparam int unsigned CFG_POL_BIT  = 17;
endpackage

// File: rtl/irqagg_group.sv
// One pending/mask register pair with write-one set and clear inputs.
module irqagg_group #(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] MASK_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] mask_q, mask_d;
  logic         pend_en;

  always_comb begin
    pend_en = (set_i != '0) || (clr_i != '0);
    pend_d  = (pend_q & ~clr_i) | set_i;   // set dominates clear
    mask_d  = mask_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      if (pend_en)   pend_q <= pend_d;
      if (mask_we_i) mask_q <= mask_d;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  // R1 / R4: a bit being set is pending afterwards, even against a clear
  p_set_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  // R1: a bit cleared without a concurrent set is gone afterwards
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irqagg_settle.sv
// Power-up hold-off: enables the output SETTLE_CYCLES edges after power rises.
module irqagg_settle #(
  parameter int unsigned SETTLE_CYCLES = 30000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);

  logic          pwr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ok_q, ok_d;
  logic          rise;

  always_comb begin
    rise  = pwr_i & ~pwr_q;
    cnt_d = cnt_q;
    ok_d  = ok_q;
    if (rise) begin
      cnt_d = CW'(SETTLE_CYCLES);
      ok_d  = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
      if ((cnt_q == CW'(1)) && pwr_i) ok_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      pwr_q <= pwr_i;
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign ok_o = ok_q;

  // R7: the enable never rises off an edge that saw power absent
  p_off_no_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_i |=> !$rose(ok_o));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 30000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_i,
  input  logic              otg_tmo_evt_i,
  input  logic              vbus_chg_evt_i,
  input  logic              reg_wr_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] SUMM_MASK =
    (DATA_W'(1) << TOP_RX_BIT) | (DATA_W'(1) << TOP_TX_BIT) | (DATA_W'(1) << TOP_DMA_BIT);

  grp_e grp;
  fn_e  fn;
  logic [DATA_W-1:0] ep_set, ep_clr, dma_set, dma_clr, top_set, top_clr;
  logic              ep_mwe, dma_mwe, top_mwe, cfg_we;
  logic [DATA_W-1:0] ep_pend, ep_mask, dma_pend, dma_mask, top_store, top_mask;
  logic [DATA_W-1:0] top_pend, evt_bits;
  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic [1:0]        ep_sum;
  logic              dma_sum, any_unmasked, settle_ok;

  // ---------------- write decode ----------------
  always_comb begin
    grp     = grp_e'(reg_addr_i[3:2]);
    fn      = fn_e'(reg_addr_i[1:0]);
    ep_set  = '0; ep_clr  = '0; ep_mwe  = 1'b0;
    dma_set = '0; dma_clr = '0; dma_mwe = 1'b0;
    top_set = '0; top_clr = '0; top_mwe = 1'b0;
    cfg_we  = 1'b0;
    if (reg_wr_i) begin
      unique case (grp)
        GRP_EP: begin
          if (fn == FN_SET)   ep_set = reg_wdata_i;
          if (fn == FN_CLEAR) ep_clr = reg_wdata_i;
          ep_mwe = (fn == FN_MASK);
        end
        GRP_DMA: begin
          if (fn == FN_SET)   dma_set = reg_wdata_i;
          if (fn == FN_CLEAR) dma_clr = reg_wdata_i;
          dma_mwe = (fn == FN_MASK);
        end
        GRP_TOP: begin
          if (fn == FN_SET)   top_set = reg_wdata_i;
          if (fn == FN_CLEAR) top_clr = reg_wdata_i;
          top_mwe = (fn == FN_MASK);
        end
        default: cfg_we = (fn == FN_STATUS);
      endcase
    end
    evt_bits = '0;
    evt_bits[TOP_OTG_BIT]  = otg_tmo_evt_i;
    evt_bits[TOP_VBUS_BIT] = vbus_chg_evt_i;
  end

  // ---------------- register groups ----------------
  irqagg_group #(.W(DATA_W), .MASK_RST('0)) u_ep_grp (
    .clk(clk), .rst_n(rst_n), .set_i(ep_set), .clr_i(ep_clr),
    .mask_we_i(ep_mwe), .mask_wdata_i(reg_wdata_i),
    .pend_o(ep_pend), .mask_o(ep_mask));

  irqagg_group #(.W(DATA_W), .MASK_RST('0)) u_dma_grp (
    .clk(clk), .rst_n(rst_n), .set_i(dma_set), .clr_i(dma_clr),
    .mask_we_i(dma_mwe), .mask_wdata_i(reg_wdata_i),
    .pend_o(dma_pend), .mask_o(dma_mask));

  // summary positions are never stored in the top-level register
  irqagg_group #(.W(DATA_W), .MASK_RST('1)) u_top_grp (
    .clk(clk), .rst_n(rst_n),
    .set_i((top_set | evt_bits) & ~SUMM_MASK), .clr_i(top_clr & ~SUMM_MASK),
    .mask_we_i(top_mwe), .mask_wdata_i(reg_wdata_i),
    .pend_o(top_store), .mask_o(top_mask));

  // ---------------- summaries ----------------
  for (genvar h = 0; h < 2; h++) begin : g_ep_half
    assign ep_sum[h] = |(ep_pend[h*HALF_W +: HALF_W] & ~ep_mask[h*HALF_W +: HALF_W]);
  end
  assign dma_sum = |(dma_pend & ~dma_mask);

  always_comb begin
    top_pend              = top_store & ~SUMM_MASK;
    top_pend[TOP_TX_BIT]  = ep_sum[0];
    top_pend[TOP_RX_BIT]  = ep_sum[1];
    top_pend[TOP_DMA_BIT] = dma_sum;
  end

  // ---------------- configuration ----------------
  always_comb cfg_d = reg_wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  // ---------------- power hold-off and output ----------------
  irqagg_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .pwr_i(pwr_on_i), .ok_o(settle_ok));

  assign any_unmasked = |(top_pend & ~top_mask);
  assign irq_o = settle_ok & (cfg_q[CFG_POL_BIT] ? any_unmasked : ~any_unmasked);

  // ---------------- read mux ----------------
  always_comb begin
    unique case (grp)
      GRP_EP:  reg_rdata_o = (fn == FN_MASK) ? ep_mask  : ep_pend;
      GRP_DMA: reg_rdata_o = (fn == FN_MASK) ? dma_mask : dma_pend;
      GRP_TOP: reg_rdata_o = (fn == FN_MASK) ? top_mask : top_pend;
      default: reg_rdata_o = (fn == FN_STATUS) ? cfg_q : '0;
    endcase
  end

  // ---------------- assertions ----------------
  // R2: clearing every endpoint bit empties both endpoint summaries
  p_ep_clear_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 4'd2 && reg_wdata_i == '1) |=>
      (!top_pend[TOP_TX_BIT] && !top_pend[TOP_RX_BIT]));

  // R3: clearing every DMA bit drops the DMA summary
  p_dma_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 4'd6 && reg_wdata_i == '1) |=> !top_pend[TOP_DMA_BIT]);

  // R4: event pulses always latch their top-level bits
  p_otg_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    otg_tmo_evt_i |=> top_pend[TOP_OTG_BIT]);
  p_vbus_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_chg_evt_i |=> top_pend[TOP_VBUS_BIT]);

  // R5: with everything masked and the hold-off released, output is the inverse polarity
  p_all_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_ok && top_mask == '1) |-> (irq_o == !cfg_q[CFG_POL_BIT]));

  // R7: a rising supply silences the output on the next cycle
  p_pwr_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on_i) |=> !irq_o);
endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
  localparam int unsigned SETTLE = 8;
  localparam logic [31:0] SUMM = (32'd1 << 8) | (32'd1 << 9) | (32'd1 << 24);

  logic        clk = 1'b0;
  logic        rst_n, pwr_on, otg_evt, vbus_evt, reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  // reference model
  logic [31:0] m_ep_p, m_ep_m, m_dma_p, m_dma_m, m_top_s, m_top_m, m_cfg;
  logic        m_ok;

  always #4 clk = ~clk;

  irq_aggregator #(.SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on), .otg_tmo_evt_i(otg_evt),
    .vbus_chg_evt_i(vbus_evt), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq));

  function automatic logic [31:0] exp_top();
    logic [31:0] r;
    r     = m_top_s & ~SUMM;
    r[9]  = |(m_ep_p[15:0] & ~m_ep_m[15:0]);
    r[8]  = |(m_ep_p[31:16] & ~m_ep_m[31:16]);
    r[24] = |(m_dma_p & ~m_dma_m);
    return r;
  endfunction

  function automatic logic exp_irq();
    logic any;
    any = |(exp_top() & ~m_top_m);
    return m_ok & (m_cfg[17] ? any : ~any);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd2:    return m_ep_p;
      4'd3:                return m_ep_m;
      4'd4, 4'd5, 4'd6:    return m_dma_p;
      4'd7:                return m_dma_m;
      4'd8, 4'd9, 4'd10:   return exp_top();
      4'd11:               return m_top_m;
      4'd12:               return m_cfg;
      default:             return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp_rd(a));
  endtask

  task automatic irq_chk(input string req);
    chk(req, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      4'd1:  m_ep_p  = m_ep_p | d;
      4'd2:  m_ep_p  = m_ep_p & ~d;
      4'd3:  m_ep_m  = d;
      4'd5:  m_dma_p = m_dma_p | d;
      4'd6:  m_dma_p = m_dma_p & ~d;
      4'd7:  m_dma_m = d;
      4'd9:  m_top_s = m_top_s | (d & ~SUMM);
      4'd10: m_top_s = m_top_s & ~d;
      4'd11: m_top_m = d;
      4'd12: m_cfg   = d;
      default: ;
    endcase
  endtask

  // event pulse, optionally overlapped with a top-level clear write
  task automatic evt(input logic otg, input logic vb, input logic [31:0] clr);
    logic [31:0] ev;
    @(negedge clk);
    otg_evt = otg; vbus_evt = vb;
    if (clr != 0) begin reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = clr; end
    @(negedge clk);
    otg_evt = 1'b0; vbus_evt = 1'b0; reg_wr = 1'b0;
    ev = ({31'd0, otg} << 16) | ({31'd0, vb} << 15);
    m_top_s = (m_top_s & ~clr) | ev;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_on = 1'b0; otg_evt = 1'b0; vbus_evt = 1'b0;
    reg_wr = 1'b0; reg_addr = 4'd0; reg_wdata = 32'd0;
    m_ep_p = 0; m_ep_m = 0; m_dma_p = 0; m_dma_m = 0; m_top_s = 0;
    m_top_m = 32'hFFFF_FFFF; m_cfg = 0; m_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 / R8: reset state over the whole address space
    for (int a = 0; a < 16; a++) rd_chk("R6", 4'(a));
    irq_chk("R6");

    // R7: power rises, output stays held for exactly SETTLE edges
    pwr_on = 1'b1;
    for (int j = 0; j <= int'(SETTLE); j++) begin
      @(negedge clk);
      m_ok = (j >= int'(SETTLE));
      irq_chk("R7");
    end

    // R5: active-low sense with nothing pending, then active-high
    irq_chk("R5");
    wr(4'd12, 32'd1 << 17);
    irq_chk("R5");
    rd_chk("R8", 4'd12);
    wr(4'd11, 32'd0);

    // R1 / R2 / R8: walk every endpoint bit
    for (int b = 0; b < 32; b++) begin
      wr(4'd1, 32'd1 << b);
      rd_chk("R1", 4'd0); rd_chk("R8", 4'd1); rd_chk("R8", 4'd2);
      rd_chk("R2", 4'd8); irq_chk("R5");
      wr(4'd3, 32'd1 << b);
      rd_chk("R2", 4'd8); rd_chk("R8", 4'd3); irq_chk("R5");
      wr(4'd3, 32'd0);
      wr(4'd2, 32'd1 << b);
      rd_chk("R1", 4'd0); rd_chk("R2", 4'd8);
    end
    // both halves together, clear one half
    wr(4'd1, 32'h0001_8000);
    rd_chk("R2", 4'd8);
    wr(4'd2, 32'h0000_8000);
    rd_chk("R2", 4'd8);
    wr(4'd2, 32'hFFFF_FFFF);
    rd_chk("R2", 4'd8);

    // R3: walk every DMA bit
    for (int b = 0; b < 32; b++) begin
      wr(4'd5, 32'd1 << b);
      rd_chk("R3", 4'd8); rd_chk("R8", 4'd6); irq_chk("R5");
      wr(4'd7, ~(32'd0));
      rd_chk("R3", 4'd8); rd_chk("R8", 4'd7);
      wr(4'd7, 32'd0);
      wr(4'd6, 32'd1 << b);
      rd_chk("R3", 4'd8); rd_chk("R8", 4'd4);
    end

    // R1 / R5 / R9: top-level software bits and masking
    for (int b = 0; b < 32; b++) begin
      wr(4'd9, 32'd1 << b);
      rd_chk((b == 8 || b == 9 || b == 24) ? "R9" : "R1", 4'd8);
      irq_chk("R5");
      wr(4'd11, 32'd1 << b);
      irq_chk("R5");
      wr(4'd11, 32'd0);
      wr(4'd10, 32'd1 << b);
      rd_chk("R1", 4'd10);
    end
    // R9: summary driven by group is not cleared through top-level clear
    wr(4'd1, 32'd1);
    wr(4'd10, 32'hFFFF_FFFF);
    rd_chk("R9", 4'd8);
    wr(4'd2, 32'd1);

    // R4: event pulses, and set beating a same-cycle clear
    evt(1'b1, 1'b0, 32'd0);
    rd_chk("R4", 4'd8);
    evt(1'b0, 1'b1, 32'd0);
    rd_chk("R4", 4'd8);
    evt(1'b1, 1'b0, 32'd1 << 16);
    rd_chk("R4", 4'd8);
    evt(1'b0, 1'b1, 32'hFFFF_FFFF);
    rd_chk("R4", 4'd8);
    irq_chk("R5");

    // R5: active-low sense with something pending, then fully masked
    wr(4'd12, 32'd0);
    irq_chk("R5");
    wr(4'd11, 32'hFFFF_FFFF);
    irq_chk("R5");

    // R7: power-off keeps the enable
    @(negedge clk); pwr_on = 1'b0;
    repeat (3) @(negedge clk);
    irq_chk("R7");
    // power back on: held, then power lost before expiry -> never enabled
    pwr_on = 1'b1;
    @(negedge clk); m_ok = 1'b0; irq_chk("R7");
    repeat (2) @(negedge clk);
    pwr_on = 1'b0;
    repeat (int'(SETTLE) + 4) @(negedge clk);
    irq_chk("R7");
    // power on again: enabled after a full window
    pwr_on = 1'b1;
    for (int j = 0; j <= int'(SETTLE); j++) begin
      @(negedge clk);
      m_ok = (j >= int'(SETTLE));
      irq_chk("R7");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule